// File: doc/BRIEF.md
# DRAM Device Model with Parallel Compare Test Mode

This block is a synthesizable, clock-sampled behavioural model of a single small DRAM device. It watches the active-low row strobe, column strobe and write enable and works out from the order of their edges which kind of cycle the controller is running. The kinds are a row-addressed read or write (column accesses inside an open row, with several in one row allowed), a refresh that takes its row from an internal counter because the column strobe was already low when the row strobe fell, and a refresh that opens a row and closes it again with no column access.

A refresh started with write enable low also switches on a latched compare test mode. In that mode the lowest column address bit is dropped, so each data pin covers a pair of neighbouring cells. A write stores the same bit in both cells of the pair, and a read returns, per pin, a 1 when the two cells agree and a 0 when they do not. The compare read arrives one clock later than a normal read. Either refresh type without write enable low ends the mode. The model can stand in for a memory device when a controller's strobe sequencing is checked.

Top module: `dram_ptest_model`

## Requirements
- R1: A column access with write enable low stores `dq_in` at the open row and column. A later read of that location has `dq_oe` high and `dq_out` equal to the stored word in the first cycle after the clock edge that samples the column strobe falling. All cells read as zero after reset.
- R2: When the row strobe falls while the column strobe and write enable are both already low, `test_mode` goes to 1 after that edge.
- R3: Once set, `test_mode` stays at 1 through any number of read and write cycles until an exit cycle occurs.
- R4: A row strobe pulse with no column strobe fall inside it is a row-only refresh. It clears `test_mode` and leaves `ref_row` unchanged.
- R5: When the row strobe falls with the column strobe already low and write enable high, the cycle is a refresh that clears `test_mode`.
- R6: In test mode, column address bit 0 is ignored. A write stores each `dq_in` bit into both cells whose columns differ only in bit 0. Once back in normal mode, both cells read back that word.
- R7: In test mode, a read drives pin b of `dq_out` to 1 when bit b of the two paired cells is equal, and to 0 when it differs. The result appears one cycle later than in R1. In the first cycle after the sampling edge, `dq_oe` is still low.
- R8: Every refresh in which the column strobe is low before the row strobe falls advances `ref_row` by one, wrapping modulo 2^ADDR_W. The external address does not affect the counter. `ref_row` is 0 after reset.
- R9: `dq_oe` is low in the cycle after any edge at which the column strobe is sampled high, and in the cycle after a write column access.
- R10: After a synchronous reset, `test_mode` is 0 and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Row address when the row strobe falls, column address when the column strobe falls |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or per-pin compare result |
| dq_oe | output | 1 | Output drive enable; low stands for high impedance |
| test_mode | output | 1 | Current compare test mode flag |
| ref_row | output | ADDR_W | Internal refresh row counter |

## Verification
The hardest case to reach is a compare read whose pin results are mixed, with some pins showing agreement and others not. It only appears when the two paired cells were written to different values while test mode was off, because any write made in test mode leaves the pair equal. The bench therefore fills both columns of a pair with distinct words in normal mode, enters test mode through the write-enable refresh sequence, and then reads the pair through each of its two column addresses. It also checks that the result appears one cycle later than a normal read.

// File: rtl/dptm_pkg.sv
package dptm_pkg;

    // One-cycle event flags produced by the strobe decoder
    typedef struct packed {
        logic cbr_test;   // refresh with CAS and WE low before RAS fall
        logic cbr_plain;  // refresh with CAS low, WE high before RAS fall
        logic ras_only;   // RAS pulse closed without any column access
        logic col_rd;     // column read inside an open row
        logic col_wr;     // column write inside an open row
    } dptm_ev_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_REFR = 2'd2
    } dptm_phase_t;

    // Per-bit agreement: 1 where the two words match
    function automatic logic [31:0] agree_bits(input logic [31:0] a, input logic [31:0] b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/dptm_strobe_decode.sv
module dptm_strobe_decode
    import dptm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output dptm_ev_t          ev,
    output logic [ADDR_W-1:0] row,
    output logic [ADDR_W-1:0] col
);

    logic        ras_q, cas_q, col_seen;
    dptm_phase_t phase;
    logic        ras_fall, ras_rise, cas_fall;

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_q & ~cas_n;

    always_comb begin
        ev.cbr_test  = ras_fall & ~cas_n & ~we_n;
        ev.cbr_plain = ras_fall & ~cas_n & we_n;
        ev.ras_only  = ras_rise & (phase == PH_ROW) & ~col_seen;
        ev.col_rd    = cas_fall & ~ras_n & (phase == PH_ROW) & we_n;
        ev.col_wr    = cas_fall & ~ras_n & (phase == PH_ROW) & ~we_n;
    end

    assign col = addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q    <= 1'b1;
            cas_q    <= 1'b1;
            phase    <= PH_IDLE;
            col_seen <= 1'b0;
            row      <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (ras_fall) begin
                col_seen <= 1'b0;
                if (!cas_n) begin
                    phase <= PH_REFR;
                end else begin
                    phase <= PH_ROW;
                    row   <= addr;
                end
            end else if (ras_rise) begin
                phase <= PH_IDLE;
            end
            if (ev.col_rd || ev.col_wr) begin
                col_seen <= 1'b1;
            end
        end
    end

    // At most one cycle kind is recognised per clock edge
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.cbr_test, ev.cbr_plain, ev.ras_only, ev.col_rd, ev.col_wr})); // R2

endmodule

// File: rtl/dptm_mode_ctrl.sv
module dptm_mode_ctrl
    import dptm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  dptm_ev_t          ev,
    output logic              test_mode,
    output logic [ADDR_W-1:0] ref_row
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic refresh_cbr;
    assign refresh_cbr = ev.cbr_test | ev.cbr_plain;

    always_ff @(posedge clk) begin
        if (rst) begin
            test_mode <= 1'b0;
            ref_row   <= '0;
        end else begin
            if (ev.cbr_test) begin
                test_mode <= 1'b1;
            end else if (ev.cbr_plain || ev.ras_only) begin
                test_mode <= 1'b0;
            end
            if (refresh_cbr) begin
                ref_row <= ref_row + ONE;
            end
        end
    end

    AST_TM_ENTER: assert property (@(posedge clk) disable iff (rst)
        ev.cbr_test |=> test_mode); // R2
    AST_TM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev.col_rd || ev.col_wr) |=> $stable(test_mode)); // R3
    AST_TM_EXIT_RAS: assert property (@(posedge clk) disable iff (rst)
        ev.ras_only |=> (!test_mode && $stable(ref_row))); // R4
    AST_TM_EXIT_CBR: assert property (@(posedge clk) disable iff (rst)
        ev.cbr_plain |=> !test_mode); // R5
    AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
        refresh_cbr |=> (ref_row == $past(ref_row) + ONE)); // R8

endmodule

// File: rtl/dptm_array.sv
module dptm_array
    import dptm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  dptm_ev_t          ev,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic              cas_n,
    input  logic              test_mode,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DQ_W-1:0] mem [DEPTH][DEPTH];
    logic [ADDR_W-1:0] col_e, col_o;
    logic [DQ_W-1:0]   rd_word, cmp_word;
    logic [DQ_W-1:0]   pend_q;
    logic              pend_v;

    assign col_e = {col[ADDR_W-1:1], 1'b0};
    assign col_o = {col[ADDR_W-1:1], 1'b1};

    always_comb begin
        rd_word  = mem[row][col];
        cmp_word = DQ_W'(agree_bits(32'(mem[row][col_e]), 32'(mem[row][col_o])));
    end

    // Cell storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) begin
                for (int c = 0; c < DEPTH; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (ev.col_wr) begin
            if (test_mode) begin
                mem[row][col_e] <= dq_in;
                mem[row][col_o] <= dq_in;
            end else begin
                mem[row][col] <= dq_in;
            end
        end
    end

    // Output path: normal reads land after one edge, compare reads after two
    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            pend_v <= 1'b0;
            if (cas_n || ev.col_wr) begin
                dq_oe <= 1'b0;
            end else if (ev.col_rd && !test_mode) begin
                dq_out <= rd_word;
                dq_oe  <= 1'b1;
            end else if (pend_v) begin
                dq_out <= pend_q;
                dq_oe  <= 1'b1;
            end
            if (ev.col_rd && test_mode) begin
                pend_q <= cmp_word;
                pend_v <= 1'b1;
            end
        end
    end

    AST_NORM_LAT: assert property (@(posedge clk) disable iff (rst)
        (ev.col_rd && !test_mode) |=> dq_oe); // R1
    AST_TEST_LAT: assert property (@(posedge clk) disable iff (rst)
        (ev.col_rd && test_mode) |=> !dq_oe); // R7
    AST_HIZ_CAS: assert property (@(posedge clk) disable iff (rst)
        cas_n |=> !dq_oe); // R9
    AST_HIZ_WR: assert property (@(posedge clk) disable iff (rst)
        ev.col_wr |=> !dq_oe); // R9

endmodule

// File: rtl/dram_ptest_model.sv
module dram_ptest_model
    import dptm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              test_mode,
    output logic [ADDR_W-1:0] ref_row
);

    dptm_ev_t          ev;
    logic [ADDR_W-1:0] row, col;

    dptm_strobe_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .ev    (ev),
        .row   (row),
        .col   (col)
    );

    dptm_mode_ctrl #(.ADDR_W(ADDR_W)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .test_mode (test_mode),
        .ref_row   (ref_row)
    );

    dptm_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .row       (row),
        .col       (col),
        .cas_n     (cas_n),
        .test_mode (test_mode),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (!test_mode && !dq_oe && ref_row == '0)); // R10

endmodule

// File: tb/dram_ptest_model_tb.sv
module dram_ptest_model_tb;

    localparam int AW = 3;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, test_mode;
    logic [AW-1:0] ref_row;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] exp_cnt = '0;

    always #10 clk = ~clk;

    dram_ptest_model #(.ADDR_W(AW), .DQ_W(DW)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_mode(test_mode), .ref_row(ref_row)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int r, input int c, input int d);
        addr = AW'(r); ras_n = 1'b0; tick();
        addr = AW'(c); we_n = 1'b0; dq_in = DW'(d); cas_n = 1'b0; tick();
        check("R9 oe low in write", int'(dq_oe), 0);
        cas_n = 1'b1; we_n = 1'b1; tick();
        ras_n = 1'b1; tick();
    endtask

    task automatic do_read(input string req, input int r, input int c, input int exp, input bit tm);
        addr = AW'(r); ras_n = 1'b0; tick();
        addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick();
        if (tm) begin
            check({req, " R7 oe low first cycle"}, int'(dq_oe), 0);
            tick();
        end
        check({req, " oe"}, int'(dq_oe), 1);
        check({req, " data"}, int'(dq_out), exp);
        cas_n = 1'b1; tick();
        check("R9 oe low after CAS high", int'(dq_oe), 0);
        ras_n = 1'b1; tick();
    endtask

    task automatic do_cbr(input bit we_low);
        addr = AW'(5); cas_n = 1'b0; we_n = we_low ? 1'b0 : 1'b1; tick();
        ras_n = 1'b0; tick();
        exp_cnt = exp_cnt + 1'b1;
        check("R8 counter step", int'(ref_row), int'(exp_cnt));
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick();
    endtask

    task automatic do_ras_only(input int r);
        addr = AW'(r); ras_n = 1'b0; tick();
        ras_n = 1'b1; tick();
    endtask

    task automatic t_reset();
        check("R10 test_mode after reset", int'(test_mode), 0);
        check("R10 oe after reset", int'(dq_oe), 0);
        check("R8 counter after reset", int'(ref_row), 0);
        do_read("R1 reset cell zero", 6, 1, 0, 1'b0);
    endtask

    task automatic t_normal();
        do_write(2, 3, 'hA);
        do_write(2, 4, 'h5);
        do_write(2, 5, 'hC);
        do_read("R1 read r2c3", 2, 3, 'hA, 1'b0);
        do_read("R1 read r2c4", 2, 4, 'h5, 1'b0);
        do_read("R1 read r2c5", 2, 5, 'hC, 1'b0);
    endtask

    task automatic t_enter_and_use();
        do_cbr(1'b1);
        check("R2 test_mode set", int'(test_mode), 1);
        do_write(1, 6, 'hA);
        check("R3 held after write", int'(test_mode), 1);
        do_read("R6 R7 pair equal via odd col", 1, 7, 'hF, 1'b1);
        do_read("R7 mixed compare", 2, 4, 'h6, 1'b1);
        do_read("R7 mixed compare col bit0 ignored", 2, 5, 'h6, 1'b1);
        check("R3 held after reads", int'(test_mode), 1);
    endtask

    task automatic t_exit_ras_only();
        do_ras_only(3);
        check("R4 test_mode cleared", int'(test_mode), 0);
        check("R4 counter unchanged", int'(ref_row), int'(exp_cnt));
        do_read("R6 even cell", 1, 6, 'hA, 1'b0);
        do_read("R6 odd cell", 1, 7, 'hA, 1'b0);
    endtask

    task automatic t_exit_cbr();
        do_cbr(1'b1);
        check("R2 re-entry", int'(test_mode), 1);
        do_cbr(1'b0);
        check("R5 test_mode cleared", int'(test_mode), 0);
        do_read("R5 normal read after exit", 2, 4, 'h5, 1'b0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 5; i++) do_cbr(1'b0);
        check("R8 counter wrapped", int'(ref_row), 0);
        check("R5 stays normal", int'(test_mode), 0);
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_normal();
        t_enter_and_use();
        t_exit_ras_only();
        t_exit_cbr();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule